// File: doc/BRIEF.md
# Programmable Overlay Processing Element

This block is one compute cell in a grid of coarse-grained cells laid over reconfigurable logic. The cell sees one data word stream from each of its eight neighbours. A loaded configuration picks one of them as the primary operand. The cell applies an arithmetic or bitwise function and emits the result two clock cycles after the operand was taken. The secondary operands D, P and B each come either from the same incoming word or from an immediate value that was loaded earlier.

The configuration lives in three 32-bit words written through a plain write port. Writes land only while `run` is low; while the cell executes, its configuration is frozen. Data leaves on a valid/ready stream. When `out_ready` is low with a result pending, the pipeline stalls as a whole and `in_ready` drops. The pending word holds steady until it is taken. A sample is accepted on a rising clock edge when the selected neighbour's valid bit and `in_ready` are both high. `in_ready` is high only while `run` is high and the output stage is empty or being drained.

Top module: `ovl_pe`

## Requirements
- R1: After reset `out_valid` is 0 and all three configuration words are zero. The zeroed mode word selects neighbour 0 with all operands taken from the stream and the function A*B+P.
- R2: Mode word bits [2:0] pick the neighbour direction (0..7); that neighbour's data is operand A and only that neighbour's valid bit can start a sample. The other neighbours' valid bits and data have no effect.
- R3: Mode bit 3 makes D come from the immediate D word instead of A; bit 4 does the same for P and bit 5 for B.
- R4: Configuration address 0 writes the mode word, address 1 the D immediate. Address 2 writes the P/B word: P is bits [31:16] and B is bits [15:0], each sign-extended to 32 bits.
- R5: Mode bits [8:6] choose the function: 0 A*B+P, 1 A+D, 2 A-D, 3 A&D, 4 A|D, 5 A^D, 6 A*B, 7 A.
- R6: A sample accepted on an edge appears on `out_data` with `out_valid` high after the next edge, i.e. two cycles after it was presented, with no back-pressure. Samples presented on consecutive cycles emerge on consecutive cycles.
- R7: While `out_valid` is high and `out_ready` low, `out_data` and `out_valid` hold and `in_ready` is low; an in-flight sample is not lost.
- R8: Configuration writes while `run` is high are ignored.
- R9: While `run` is low no sample is accepted and `in_ready` is low.
- R10: All results are the low 32 bits of the exact result (wrap-around).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Execute enable; freezes configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| nb_data | input | 256 | Eight neighbour words, neighbour i at bits [32i+31:32i] |
| nb_valid | input | 8 | Per-neighbour valid |
| in_ready | output | 1 | Cell can accept a sample from the selected neighbour |
| out_data | output | 32 | Result word |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |

## Verification
The bench puts distinct junk on every unselected neighbour. A direction decoder that is off by one, or that trusts the wrong valid bit, produces a wrong word or a phantom result. Each operand-source bit is toggled against a function that uses it, so a swapped D/P/B select or a missing sign extension of the packed immediates shows up as an arithmetic mismatch. Latency is checked both ways: a result one edge early is caught, and so is a bubble between back-to-back samples. A stalled output that changes, or a second sample that is dropped during the stall, fails the back-pressure test. A write during execution that leaks through shifts the sum of the following sample.

// File: rtl/ovl_pe_pkg.sv
package ovl_pe_pkg;
  localparam int NB_DIRS = 8;
  localparam int DIR_W   = $clog2(NB_DIRS);

  typedef enum logic [2:0] {
    OP_MAC  = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_MUL  = 3'd6,
    OP_PASS = 3'd7
  } op_e;

  // packed: op[8:6], b_imm[5], p_imm[4], d_imm[3], dir[2:0]
  typedef struct packed {
    op_e              op;
    logic             b_imm;
    logic             p_imm;
    logic             d_imm;
    logic [DIR_W-1:0] dir;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  typedef enum logic [1:0] {
    CFG_MODE  = 2'd0,
    CFG_DIMM  = 2'd1,
    CFG_PBIMM = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/ovl_pe_cfg.sv
module ovl_pe_cfg
  import ovl_pe_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  output mode_t        mode,
  output logic [W-1:0] d_imm,
  output logic [W-1:0] p_imm,
  output logic [W-1:0] b_imm
);
  localparam int HW = W / 2;

  logic          wr_ok;
  logic [MODE_W-1:0] mode_q;
  logic [W-1:0]  dimm_q;
  logic [W-1:0]  pbimm_q;

  assign wr_ok = cfg_we && !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      dimm_q  <= '0;
      pbimm_q <= '0;
    end else if (wr_ok) begin
      case (cfg_addr)
        CFG_MODE:  mode_q  <= cfg_wdata[MODE_W-1:0];
        CFG_DIMM:  dimm_q  <= cfg_wdata;
        CFG_PBIMM: pbimm_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  assign mode  = mode_t'(mode_q);
  assign d_imm = dimm_q;
  assign p_imm = {{(W-HW){pbimm_q[W-1]}}, pbimm_q[W-1:HW]};
  assign b_imm = {{(W-HW){pbimm_q[HW-1]}}, pbimm_q[HW-1:0]};
endmodule

// File: rtl/ovl_pe_opsel.sv
module ovl_pe_opsel
  import ovl_pe_pkg::*;
#(
  parameter int W  = 32,
  parameter int NB = NB_DIRS
) (
  input  logic [NB*W-1:0] nb_data,
  input  logic [NB-1:0]   nb_valid,
  input  mode_t           mode,
  input  logic [W-1:0]    d_imm,
  input  logic [W-1:0]    p_imm,
  input  logic [W-1:0]    b_imm,
  output logic [W-1:0]    opa,
  output logic [W-1:0]    opb,
  output logic [W-1:0]    opd,
  output logic [W-1:0]    opp,
  output logic            sel_valid
);
  logic [W-1:0] lane [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane[g] = nb_data[g*W +: W];
  end

  assign opa       = lane[mode.dir];
  assign sel_valid = nb_valid[mode.dir];
  assign opd       = mode.d_imm ? d_imm : opa;
  assign opp       = mode.p_imm ? p_imm : opa;
  assign opb       = mode.b_imm ? b_imm : opa;
endmodule

// File: rtl/ovl_pe_core.sv
module ovl_pe_core
  import ovl_pe_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         load,
  input  op_e          op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] opd,
  input  logic [W-1:0] opp,
  output logic         s1_valid,
  output logic [W-1:0] res,
  output logic         res_valid
);
  logic [W-1:0] a_q, b_q, d_q, p_q;
  op_e          op_q;
  logic [W-1:0] prod;
  logic [W-1:0] fn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      a_q <= '0; b_q <= '0; d_q <= '0; p_q <= '0;
      op_q <= OP_MAC;
    end else if (adv) begin
      s1_valid <= load;
      if (load) begin
        a_q  <= opa;
        b_q  <= opb;
        d_q  <= opd;
        p_q  <= opp;
        op_q <= op;
      end
    end
  end

  assign prod = a_q * b_q;

  always_comb begin
    case (op_q)
      OP_MAC:  fn = prod + p_q;
      OP_ADD:  fn = a_q + d_q;
      OP_SUB:  fn = a_q - d_q;
      OP_AND:  fn = a_q & d_q;
      OP_OR:   fn = a_q | d_q;
      OP_XOR:  fn = a_q ^ d_q;
      OP_MUL:  fn = prod;
      default: fn = a_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res       <= '0;
    end else if (adv) begin
      res_valid <= s1_valid;
      if (s1_valid) res <= fn;
    end
  end
endmodule

// File: rtl/ovl_pe.sv
module ovl_pe
  import ovl_pe_pkg::*;
#(
  parameter int W  = 32,
  parameter int NB = NB_DIRS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [W-1:0]  cfg_wdata,
  input  logic [NB*W-1:0] nb_data,
  input  logic [NB-1:0] nb_valid,
  output logic          in_ready,
  output logic [W-1:0]  out_data,
  output logic          out_valid,
  input  logic          out_ready
);
  mode_t        mode;
  logic [W-1:0] d_imm, p_imm, b_imm;
  logic [W-1:0] opa, opb, opd, opp;
  logic         sel_valid, adv, fire, s1_valid;

  ovl_pe_cfg #(.W(W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .mode(mode),
    .d_imm(d_imm), .p_imm(p_imm), .b_imm(b_imm)
  );

  ovl_pe_opsel #(.W(W), .NB(NB)) u_sel (
    .nb_data(nb_data), .nb_valid(nb_valid), .mode(mode),
    .d_imm(d_imm), .p_imm(p_imm), .b_imm(b_imm),
    .opa(opa), .opb(opb), .opd(opd), .opp(opp), .sel_valid(sel_valid)
  );

  assign adv      = !out_valid || out_ready;
  assign in_ready = run && adv;
  assign fire     = in_ready && sel_valid;

  ovl_pe_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(fire), .op(mode.op),
    .opa(opa), .opb(opb), .opd(opd), .opp(opp),
    .s1_valid(s1_valid), .res(out_data), .res_valid(out_valid)
  );
endmodule

// File: rtl/ovl_pe_chk.sv
module ovl_pe_chk #(
  parameter int W = 32,
  parameter int MW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          fire,
  input logic          s1_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_data,
  input logic [MW-1:0] mode_bits,
  input logic [W-1:0]  d_imm,
  input logic [W-1:0]  p_imm,
  input logic [W-1:0]  b_imm
);
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(mode_bits) && $stable(d_imm) && $stable(p_imm) && $stable(b_imm)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R7
  AST_LAT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    fire ##1 (out_ready || !out_valid) |=> out_valid); // R6
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s1_valid)); // R6
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !s1_valid |=> !s1_valid); // R9
endmodule

bind ovl_pe ovl_pe_chk #(.W(W), .MW(ovl_pe_pkg::MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .fire(fire), .s1_valid(s1_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .mode_bits(mode), .d_imm(d_imm), .p_imm(p_imm),
  .b_imm(b_imm)
);

// File: tb/sim_ovl_pe.sv
`timescale 1ns/1ps
module sim_ovl_pe;
  localparam int W = 32;
  localparam int NB = 8;
  localparam int NV = 10;
  // {mode, d_imm, pb_imm, a_data, expected}
  localparam logic [159:0] VECS [NV] = '{
    {32'h04A, 32'h5,        32'h0,        32'd10,       32'd15},         // R5 R3 ADD imm
    {32'h08F, 32'h3,        32'h0,        32'd1,        32'hFFFFFFFE},   // R5 R10 SUB dir7
    {32'h030, 32'h0,        32'h00100003, 32'd7,        32'h25},         // R4 MAC imm P,B
    {32'h005, 32'h0,        32'h0,        32'd4,        32'h14},         // R3 MAC stream
    {32'h0CB, 32'h0F0F0F0F, 32'h0,        32'h12345678, 32'h02040608},   // R5 AND
    {32'h109, 32'hF0000000, 32'h0,        32'h0000000F, 32'hF000000F},   // R5 OR
    {32'h14C, 32'hFFFFFFFF, 32'h0,        32'h12345678, 32'hEDCBA987},   // R5 XOR
    {32'h1A6, 32'h0,        32'h0000FFFF, 32'd5,        32'hFFFFFFFB},   // R4 MUL B=-1
    {32'h1C1, 32'h0,        32'h0,        32'hCAFEF00D, 32'hCAFEF00D},   // R5 PASS
    {32'h046, 32'h0,        32'h0,        32'h80000000, 32'h0}           // R10 A+A wrap
  };

  logic clk = 0, rst_n = 0, run = 0, cfg_we = 0, out_ready = 1;
  logic [1:0] cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic [NB*W-1:0] nb_data = '0;
  logic [NB-1:0] nb_valid = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ovl_pe u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .nb_data(nb_data), .nb_valid(nb_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic junk();
    for (int i = 0; i < NB; i++) nb_data[i*W +: W] = 32'hBAD00000 | i;
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic configure(input logic [W-1:0] m, input logic [W-1:0] d,
                           input logic [W-1:0] pb);
    @(negedge clk); run = 0;
    cfg_wr(2'd0, m); cfg_wr(2'd1, d); cfg_wr(2'd2, pb);
    @(negedge clk); run = 1;
  endtask

  // presents one sample, then checks the result two cycles later
  task automatic send_check(input int dir, input logic [W-1:0] a,
                            input logic [W-1:0] exp, input string req);
    @(negedge clk);
    junk();
    nb_data[dir*W +: W] = a; nb_valid = '0; nb_valid[dir] = 1'b1;
    @(negedge clk);
    nb_valid = '0;
    chk(out_valid == 1'b0, "R6 early", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    chk(out_valid == 1'b1, req, {31'd0, out_valid}, 32'd1);
    chk(out_data == exp, req, out_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    junk();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1 out_valid", {31'd0, out_valid}, 0);
    chk(in_ready == 0, "R9 in_ready idle", {31'd0, in_ready}, 0);
    // R9 no acceptance while idle
    nb_valid = '1;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R9 idle accept", {31'd0, out_valid}, 0);
    nb_valid = '0;
    // R1 zero config: dir 0, all stream, A*A+A
    @(negedge clk); run = 1;
    send_check(0, 32'd3, 32'd12, "R1 default mode");

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [159:0] v;
      v = VECS[i];
      configure(v[159:128], v[127:96], v[95:64]);
      send_check(int'(v[130:128]), v[63:32], v[31:0], "R5 R2 vector");
    end

    // R8 write during run ignored
    configure(32'h04A, 32'd5, 32'd0);
    cfg_wr(2'd1, 32'd100);
    send_check(2, 32'd10, 32'd15, "R8 write while running");

    // R2 other neighbours' valid ignored
    configure(32'h04C, 32'd0, 32'd0);
    @(negedge clk);
    nb_valid = 8'hEF;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R2 wrong valid", {31'd0, out_valid}, 0);
    nb_valid = '0;
    send_check(4, 32'h44, 32'h44, "R2 selected dir");

    // R6 back-to-back
    configure(32'h048, 32'd1, 32'd0);
    @(negedge clk);
    nb_data[0 +: W] = 32'd10; nb_valid = 8'h01;
    @(negedge clk);
    nb_data[0 +: W] = 32'd20;
    @(negedge clk);
    nb_valid = '0;
    chk(out_valid && out_data == 32'd11, "R6 first", out_data, 32'd11);
    @(negedge clk);
    chk(out_valid && out_data == 32'd21, "R6 second", out_data, 32'd21);

    // R7 back-pressure
    @(negedge clk);
    out_ready = 0;
    nb_data[0 +: W] = 32'd10; nb_valid = 8'h01;
    @(negedge clk);
    nb_data[0 +: W] = 32'd20;
    @(negedge clk);
    nb_valid = '0;
    chk(out_valid && out_data == 32'd11, "R7 stalled out", out_data, 32'd11);
    chk(in_ready == 0, "R7 in_ready low", {31'd0, in_ready}, 0);
    @(negedge clk);
    chk(out_valid && out_data == 32'd11, "R7 hold", out_data, 32'd11);
    out_ready = 1;
    @(negedge clk);
    chk(out_valid && out_data == 32'd21, "R7 second kept", out_data, 32'd21);
    @(negedge clk);
    chk(out_valid == 0, "R7 drained", {31'd0, out_valid}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule